// File: doc/BRIEF.md
# Four-Mode Serial Port Engine

This block is a serial port that runs in one of four modes chosen by a two-bit mode input. Mode 0 is a synchronous shift output. It drives a data line and a shift clock so that external shift registers can widen the parallel outputs. Mode 1 sends and receives asynchronous frames with eight data bits. Modes 2 and 3 do the same with a ninth data bit. When transmitting, the ninth bit comes from an input that software sets before the write. When receiving, the ninth bit is kept beside the received byte.

In mode 2 the bit rate is a fixed fraction of the system clock. In modes 1 and 3 the bit rate follows single-cycle overflow pulses from an external timer. In modes 1, 2 and 3 a doubling input halves the bit time. A write to the transmit data input starts a frame. A transmit-done flag and a receive-done flag report finished frames and stay set until they are cleared.

Top module: `sport4_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), txd and shclk are 1, and tx_done and rx_done are 0.
- R2: In mode 0 (mode=0), a write sends the eight bits of wr_data on txd, least significant bit first, with no start or stop bit. Each bit lasts 12 clocks. shclk is low for the first 6 clocks of each bit and high for the last 6. txd is steady at each rising edge of shclk, and tx_done is set after the eighth bit.
- R3: In modes 1, 2 and 3 a transmit frame has the following bits in order:
  - a start bit of 0;
  - wr_data, least significant bit first;
  - in modes 2 and 3 only, the value of tx_bit9 captured at the write;
  - a stop bit of 1.
- R4: In mode 2 each asynchronous bit lasts 64 clocks when dbl=0 and 32 clocks when dbl=1. The frame runs from the falling edge of the start bit to the setting of tx_done, and lasts exactly the bit count times the bit time.
- R5: In modes 1 and 3 each bit lasts 32 tmr_ovf periods when dbl=0 and 16 periods when dbl=1.
- R6: tx_done is set when a frame ends. It stays set until a clr_tx pulse clears it.
- R7: With rx_en=1 in modes 1, 2 and 3, the receiver does the following:
  - it samples each incoming bit three times near mid-bit and takes the majority value;
  - it assembles the data bits least significant bit first;
  - at a valid stop bit it puts the byte on rd_data and sets rx_done;
  - rx_done stays set until clr_rx clears it.
- R8: In modes 2 and 3 the received ninth bit appears on rx_bit9 together with rd_data.
- R9: A low pulse on rxd shorter than half a bit time is rejected as a false start. It does not set rx_done.
- R10: A write while a frame is in progress is ignored. The current frame completes unchanged, and no second frame follows.
- R11: With rx_en=0 an incoming frame is not received, and rx_done stays 0.
- R12: A received frame whose stop bit samples as 0 is discarded without setting rx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 shift, 1 async 8-bit timer rate, 2 async 9-bit fixed rate, 3 async 9-bit timer rate |
| dbl | input | 1 | Rate doubling control |
| tmr_ovf | input | 1 | One-cycle overflow pulse from the external timer |
| wr_stb | input | 1 | Write strobe: starts a transmit frame |
| wr_data | input | 8 | Byte to transmit |
| tx_bit9 | input | 1 | Ninth transmit bit, captured at the write |
| clr_tx | input | 1 | Clears tx_done |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial receive line |
| clr_rx | input | 1 | Clears rx_done |
| txd | output | 1 | Serial transmit line (shift data in mode 0) |
| shclk | output | 1 | Shift clock for mode 0, idle high |
| tx_done | output | 1 | Transmit-done flag |
| rd_data | output | 8 | Last byte received |
| rx_bit9 | output | 1 | Ninth bit of the last 9-bit frame received |
| rx_done | output | 1 | Receive-done flag |

## Verification
The assertions rely on two conditions at the inputs:
- mode and dbl stay constant while a frame is in flight;
- tmr_ovf is a single-cycle pulse no more often than every other clock.

The bench meets both conditions:
- it changes mode and dbl only between frames, after the done flag has been seen;
- it pulses tmr_ovf once every three clocks.

The bench holds each serial bit on rxd for an exact whole number of clocks equal to the nominal bit time. As a result, the three mid-bit samples always land inside the bit they belong to.

// File: rtl/sport4_pkg.sv
// Shared definitions for the four-mode serial port.
package sport4_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'd0,
        MODE_ASY8  = 2'd1,
        MODE_FIX9  = 2'd2,
        MODE_TMR9  = 2'd3
    } port_mode_t;

    localparam int OS_RATE = 16;   // oversampling ticks per asynchronous bit
endpackage

// File: rtl/sport4_baud.sv
// Oversampling tick generator.
// Mode 2: one tick every M2_DIV/16 clocks, or half that when dbl is set.
// Modes 1 and 3: one tick every second timer overflow, or every overflow when dbl is set.
// Assumes M2_DIV is a multiple of 32 and tmr_ovf is a one-cycle pulse.
module sport4_baud #(
    parameter int M2_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       dbl,
    input  logic       tmr_ovf,
    output logic       os_tick
);
    import sport4_pkg::*;

    localparam int FIX_STEP = M2_DIV / OS_RATE;
    localparam int CW       = (FIX_STEP > 2) ? $clog2(FIX_STEP) : 1;

    logic [CW-1:0] div_q;
    logic          half_q;
    logic [CW-1:0] lim;

    // Terminal count of the fixed-rate divider.
    always_comb lim = dbl ? CW'(FIX_STEP / 2 - 1) : CW'(FIX_STEP - 1);

    // Produce one registered tick per oversample period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            half_q  <= 1'b0;
            os_tick <= 1'b0;
        end else begin
            os_tick <= 1'b0;
            if (mode == MODE_FIX9) begin
                if (div_q >= lim) begin
                    div_q   <= '0;
                    os_tick <= 1'b1;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end else if (tmr_ovf) begin
                half_q  <= ~half_q;
                os_tick <= dbl | half_q;
            end
        end
    end

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIX9 && $past(mode) == MODE_FIX9 && os_tick) |=> !os_tick);
endmodule

// File: rtl/sport4_tx.sv
// Transmitter.
// Mode 0 shifts DW bits out with a shift clock, each bit lasting M0_DIV clocks.
// The other modes send start, data (least significant bit first), an optional ninth bit and stop.
// Each asynchronous bit spans OS_RATE ticks.
// Assumes mode is constant during a frame; a write while busy is ignored.
module sport4_tx #(
    parameter int DW     = 8,
    parameter int M0_DIV = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          os_tick,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          tx_bit9,
    input  logic          clr_tx,
    output logic          txd,
    output logic          shclk,
    output logic          tx_done
);
    import sport4_pkg::*;

    localparam int FW   = DW + 3;
    localparam int LW   = $clog2(FW + 1);
    localparam int SMAX = (M0_DIV > OS_RATE) ? M0_DIV : OS_RATE;
    localparam int SW   = $clog2(SMAX);

    logic          busy_q, pend_q, sync_q;
    logic [FW-1:0] sh_q;
    logic [LW-1:0] left_q;
    logic [SW-1:0] sub_q;

    // Frame sequencing, bit timing and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            pend_q  <= 1'b0;
            sync_q  <= 1'b0;
            sh_q    <= '1;
            left_q  <= '0;
            sub_q   <= '0;
            txd     <= 1'b1;
            shclk   <= 1'b1;
            tx_done <= 1'b0;
        end else begin
            if (clr_tx) tx_done <= 1'b0;
            if (!busy_q) begin
                if (wr_stb) begin
                    busy_q <= 1'b1;
                    sub_q  <= '0;
                    if (mode == MODE_SHIFT) begin
                        sync_q <= 1'b1;
                        pend_q <= 1'b0;
                        sh_q   <= {{(FW-DW){1'b1}}, wr_data};
                        left_q <= LW'(DW);
                        txd    <= wr_data[0];
                        shclk  <= 1'b0;
                    end else begin
                        sync_q <= 1'b0;
                        pend_q <= 1'b1;
                        sh_q   <= {1'b1, (mode[1] ? tx_bit9 : 1'b1), wr_data, 1'b0};
                        left_q <= mode[1] ? LW'(DW + 3) : LW'(DW + 2);
                    end
                end
            end else if (sync_q) begin
                if (sub_q == SW'(M0_DIV - 1)) begin
                    sub_q <= '0;
                    if (left_q == LW'(1)) begin
                        busy_q  <= 1'b0;
                        tx_done <= 1'b1;
                        txd     <= 1'b1;
                        shclk   <= 1'b1;
                    end else begin
                        sh_q   <= {1'b1, sh_q[FW-1:1]};
                        txd    <= sh_q[1];
                        shclk  <= 1'b0;
                        left_q <= left_q - 1'b1;
                    end
                end else begin
                    sub_q <= sub_q + 1'b1;
                    if (sub_q == SW'(M0_DIV / 2 - 1)) shclk <= 1'b1;
                end
            end else if (os_tick) begin
                if (pend_q) begin
                    pend_q <= 1'b0;
                    txd    <= sh_q[0];
                    sub_q  <= '0;
                end else if (sub_q == SW'(OS_RATE - 1)) begin
                    sub_q <= '0;
                    if (left_q == LW'(1)) begin
                        busy_q  <= 1'b0;
                        tx_done <= 1'b1;
                        txd     <= 1'b1;
                    end else begin
                        sh_q   <= {1'b1, sh_q[FW-1:1]};
                        txd    <= sh_q[1];
                        left_q <= left_q - 1'b1;
                    end
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end
        end
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (txd && shclk));
    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(busy_q));
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !clr_tx) |=> tx_done);
endmodule

// File: rtl/sport4_rx.sv
// Asynchronous receiver for modes 1 to 3.
// It detects a low start bit on an oversampling tick and takes three samples at ticks 7 to 9 of each bit.
// The majority value is used. A start bit that is high at mid-bit or a stop bit that is low ends the frame with no result.
// Assumes mode is constant during a frame.
module sport4_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          os_tick,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic          clr_rx,
    output logic [DW-1:0] rd_data,
    output logic          rx_bit9,
    output logic          rx_done
);
    import sport4_pkg::*;

    localparam int IW = $clog2(DW + 3);

    logic          s1_q, s2_q, active_q, nine_q, maj;
    logic [3:0]    sub_q;
    logic [IW-1:0] idx_q, last_idx;
    logic [1:0]    vote_q;
    logic [DW:0]   shf_q;

    // Majority of the two stored samples and the current one.
    always_comb begin
        maj      = (vote_q[1] & vote_q[0]) | (vote_q[1] & s2_q) | (vote_q[0] & s2_q);
        last_idx = nine_q ? IW'(DW + 2) : IW'(DW + 1);
    end

    // Bring rxd into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
        end
    end

    // Start detection, bit sampling, assembly and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            nine_q   <= 1'b0;
            sub_q    <= '0;
            idx_q    <= '0;
            vote_q   <= '0;
            shf_q    <= '0;
            rd_data  <= '0;
            rx_bit9  <= 1'b0;
            rx_done  <= 1'b0;
        end else begin
            if (clr_rx) rx_done <= 1'b0;
            if (!active_q) begin
                if (os_tick && rx_en && !s2_q && mode != MODE_SHIFT) begin
                    active_q <= 1'b1;
                    nine_q   <= mode[1];
                    sub_q    <= 4'd1;
                    idx_q    <= '0;
                end
            end else if (os_tick) begin
                sub_q <= sub_q + 1'b1;
                if (sub_q == 4'd7 || sub_q == 4'd8) vote_q <= {vote_q[0], s2_q};
                if (sub_q == 4'd15) idx_q <= idx_q + 1'b1;
                if (sub_q == 4'd9) begin
                    if (idx_q == '0) begin
                        if (maj) active_q <= 1'b0;
                    end else if (idx_q == last_idx) begin
                        active_q <= 1'b0;
                        if (maj) begin
                            rx_done <= 1'b1;
                            if (nine_q) begin
                                rd_data <= shf_q[DW-1:0];
                                rx_bit9 <= shf_q[DW];
                            end else begin
                                rd_data <= shf_q[DW:1];
                            end
                        end
                    end else begin
                        shf_q <= {maj, shf_q[DW:1]};
                    end
                end
            end
        end
    end

    assert_disabled_stays_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !active_q) |=> !active_q);
    assert_rx_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_rx) |=> rx_done);
    assert_rx_done_needs_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(active_q));
endmodule

// File: rtl/sport4_top.sv
// Four-mode serial port: ties together the tick generator, the transmitter and the receiver.
// Assumes mode and dbl change only between frames.
module sport4_top #(
    parameter int DW     = 8,
    parameter int M0_DIV = 12,
    parameter int M2_DIV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          dbl,
    input  logic          tmr_ovf,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          tx_bit9,
    input  logic          clr_tx,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic          clr_rx,
    output logic          txd,
    output logic          shclk,
    output logic          tx_done,
    output logic [DW-1:0] rd_data,
    output logic          rx_bit9,
    output logic          rx_done
);
    logic os_tick;

    sport4_baud #(.M2_DIV(M2_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(dbl),
        .tmr_ovf(tmr_ovf), .os_tick(os_tick)
    );

    sport4_tx #(.DW(DW), .M0_DIV(M0_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .tx_bit9(tx_bit9), .clr_tx(clr_tx),
        .txd(txd), .shclk(shclk), .tx_done(tx_done)
    );

    sport4_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
        .rx_en(rx_en), .rxd(rxd), .clr_rx(clr_rx),
        .rd_data(rd_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
    );
endmodule

// File: tb/sport4_top_test.sv
// Self-checking bench: sweeps bytes and modes, computes frames and bit times arithmetically.
module sport4_top_test;
    localparam int OVF_P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       dbl = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_bit9 = 1'b0;
    logic       clr_tx = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic       clr_rx = 1'b0;
    logic       txd, shclk, tx_done, rx_bit9, rx_done;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    sport4_top uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(dbl), .tmr_ovf(tmr_ovf),
        .wr_stb(wr_stb), .wr_data(wr_data), .tx_bit9(tx_bit9), .clr_tx(clr_tx),
        .rx_en(rx_en), .rxd(rxd), .clr_rx(clr_rx),
        .txd(txd), .shclk(shclk), .tx_done(tx_done),
        .rd_data(rd_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
    );

    always #2.5 clk = ~clk;

    // Timer overflow: one-cycle pulse every OVF_P clocks.
    initial begin
        forever begin
            repeat (OVF_P - 1) @(negedge clk);
            tmr_ovf = 1'b1;
            @(negedge clk);
            tmr_ovf = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d, input logic b9);
        @(negedge clk);
        wr_data = d; tx_bit9 = b9; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        clr_tx = 1'b1; clr_rx = 1'b1;
        @(negedge clk);
        clr_tx = 1'b0; clr_rx = 1'b0;
    endtask

    function automatic int bit_time(input logic [1:0] m, input logic d);
        if (m == 2'd2) return d ? 32 : 64;
        return d ? 16 * OVF_P : 32 * OVF_P;
    endfunction

    // Mode 0 shift output check (R2).
    task automatic tx_shift(input logic [7:0] d);
        logic [7:0] got = 8'h00;
        int nb = 0, gap = 0, lastrise = -1, t = 0;
        logic prev = 1'b1;
        mode = 2'd0;
        clear_flags();
        do_write(d, 1'b0);
        prev = shclk;
        while (nb < 8 && t < 400) begin
            @(negedge clk); t++;
            if (shclk && !prev) begin
                got[nb] = txd;
                if (lastrise >= 0) begin
                    gap = t - lastrise;
                    chk("R2 shift bit period", gap, 12);
                end
                lastrise = t;
                nb++;
            end
            prev = shclk;
        end
        repeat (8) @(negedge clk);
        chk("R2 shift data", int'(got), int'(d));
        chk("R2 shift done", int'(tx_done), 1);
    endtask

    // Asynchronous transmit check (R3 to R6, optional R10 interference).
    task automatic tx_async(input logic [1:0] m, input logic d2, input logic [7:0] d,
                            input logic b9, input bit meddle);
        int bt, nbits, cnt, k, t;
        logic [11:0] exp_f, got_f;
        mode = m; dbl = d2;
        clear_flags();
        bt = bit_time(m, d2);
        nbits = m[1] ? 11 : 10;
        exp_f = m[1] ? {1'b0, 1'b1, b9, d, 1'b0} : {2'b00, 1'b1, d, 1'b0};
        got_f = '0;
        do_write(d, b9);
        t = 0;
        while (txd && t < 4 * bt) begin @(negedge clk); t++; end
        cnt = 0; k = 0;
        while (!tx_done && cnt < 13 * bt) begin
            if (cnt == bt / 2 + k * bt && k < 12) begin got_f[k] = txd; k++; end
            if (meddle && cnt == 3 * bt) begin
                wr_data = ~d; wr_stb = 1'b1;
            end else begin
                wr_stb = 1'b0;
            end
            @(negedge clk); cnt++;
        end
        wr_stb = 1'b0;
        chk(m[1] ? "R3 nine-bit frame" : "R3 eight-bit frame", int'(got_f), int'(exp_f));
        chk(m == 2'd2 ? "R4 fixed-rate frame length" : "R5 timer-rate frame length",
            cnt, nbits * bt);
        chk("R6 tx_done set", int'(tx_done), 1);
        if (meddle) begin
            t = 0;
            repeat (2 * bt) begin @(negedge clk); if (!txd) t++; end
            chk("R10 no second frame after busy write", t, 0);
        end
        repeat (5) @(negedge clk);
        chk("R6 tx_done holds", int'(tx_done), 1);
        clear_flags();
        chk("R6 tx_done cleared", int'(tx_done), 0);
    endtask

    task automatic drive_frame(input logic [1:0] m, input int bt, input logic [7:0] d,
                               input logic b9, input logic stopv);
        rxd = 1'b0; repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bt) @(negedge clk); end
        if (m[1]) begin rxd = b9; repeat (bt) @(negedge clk); end
        rxd = stopv; repeat (bt) @(negedge clk);
        rxd = 1'b1; repeat (bt) @(negedge clk);
    endtask

    // Receive check (R7, R8).
    task automatic rx_frame(input logic [1:0] m, input logic d2, input logic [7:0] d,
                            input logic b9);
        int bt;
        mode = m; dbl = d2;
        clear_flags();
        bt = bit_time(m, d2);
        drive_frame(m, bt, d, b9, 1'b1);
        chk("R7 rx_done set", int'(rx_done), 1);
        chk("R7 rx data", int'(rd_data), int'(d));
        if (m[1]) chk("R8 ninth bit", int'(rx_bit9), int'(b9));
        repeat (3) @(negedge clk);
        chk("R7 rx_done holds", int'(rx_done), 1);
        clear_flags();
        chk("R7 rx_done cleared", int'(rx_done), 0);
    endtask

    initial begin
        int bt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd idle", int'(txd), 1);
        chk("R1 shclk idle", int'(shclk), 1);
        chk("R1 tx_done", int'(tx_done), 0);
        chk("R1 rx_done", int'(rx_done), 0);

        for (int i = 0; i < 6; i++) tx_shift(8'(8'h5A * i + 8'h13));
        tx_shift(8'h00);
        tx_shift(8'hFF);

        for (int i = 0; i < 3; i++) tx_async(2'd1, 1'b0, 8'(8'h3C + 8'h47 * i), 1'b0, 1'b0);
        tx_async(2'd1, 1'b1, 8'hA5, 1'b0, 1'b0);
        tx_async(2'd2, 1'b0, 8'h81, 1'b1, 1'b0);
        tx_async(2'd2, 1'b1, 8'h7E, 1'b0, 1'b0);
        tx_async(2'd3, 1'b0, 8'hC3, 1'b1, 1'b0);
        tx_async(2'd3, 1'b1, 8'h18, 1'b0, 1'b0);
        tx_async(2'd2, 1'b1, 8'h96, 1'b1, 1'b1);

        rx_en = 1'b1;
        for (int i = 0; i < 3; i++) rx_frame(2'd1, 1'b0, 8'(8'hB1 + 8'h35 * i), 1'b0);
        rx_frame(2'd1, 1'b1, 8'h00, 1'b0);
        rx_frame(2'd2, 1'b0, 8'hFF, 1'b1);
        rx_frame(2'd2, 1'b1, 8'h6D, 1'b0);
        rx_frame(2'd3, 1'b0, 8'h92, 1'b1);
        rx_frame(2'd3, 1'b1, 8'h4B, 1'b0);

        // R9: a short low pulse is not a start bit.
        mode = 2'd2; dbl = 1'b0; bt = 64;
        clear_flags();
        rxd = 1'b0; repeat (bt / 4) @(negedge clk);
        rxd = 1'b1; repeat (3 * bt) @(negedge clk);
        chk("R9 false start rejected", int'(rx_done), 0);
        rx_frame(2'd2, 1'b0, 8'h2D, 1'b1);

        // R12: a low stop bit discards the frame.
        mode = 2'd1; dbl = 1'b0; bt = bit_time(2'd1, 1'b0);
        clear_flags();
        drive_frame(2'd1, bt, 8'hE7, 1'b0, 1'b0);
        repeat (2 * bt) @(negedge clk);
        chk("R12 bad stop discarded", int'(rx_done), 0);

        // R11: receiver disabled.
        rx_en = 1'b0;
        clear_flags();
        drive_frame(2'd1, bt, 8'h5C, 1'b0, 1'b1);
        chk("R11 disabled receiver", int'(rx_done), 0);
        rx_en = 1'b1;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule